// File: doc/BRIEF.md
# Cascadable Up/Down Counter Pair

This block holds two 16-bit up/down counters. Each counter moves by one on an up or a down strobe, and each has its own preload register and capture register. A falling edge on a counter's external load pin copies its preload value into the counter. A falling edge on its capture pin stores the current count. A clear pin zeroes the counter. One mode pin chooses whether that clear acts at the next clock edge or at once, with no clock.

A cascade pin joins the two counters into one 32-bit counter. Unit 0 then holds the low half. Unit 1 holds the high half and steps on the wrap strobes of unit 0 in the same clock edge. In this mode the strobe, clear, load and capture pins of unit 0 control both halves. A small register port writes the preload values and reads back preload, count and capture values. The full count is also available on a parallel output, together with one wrap flag per unit.

Top module: `updn_cascade_counter`

## Requirements
- R1: After a synchronous reset, both counts, both preload registers, both capture registers, the wrap flags and `rdata_o` are all zero.
- R2: For each unit, at each clock edge:
  - An up strobe alone adds one, modulo 2^16.
  - A down strobe alone subtracts one, modulo 2^16.
  - Both strobes together, or neither, leave the count unchanged.
- R3: A load event is a clock edge at which the load pin was sampled high at the previous edge and is sampled low at this edge. At a load event, the counter takes the preload value held before that edge. A load event overrides any up or down strobe in the same cycle.
- R4: A capture event is defined the same way on the capture pin. At a capture event, the capture register stores the count held just before that edge.
- R5: Clear behaviour depends on `aclr_mode_i`:
  - With `aclr_mode_i`=0, a high clear pin zeroes the count at the next edge, overriding load and strobes.
  - With `aclr_mode_i`=1, a high clear pin forces the count to zero at once, without a clock edge, and holds it there while the pin stays high.
- R6: `carry_o[u]` is high for exactly the cycle after an edge where unit u stepped up from 0xFFFF to 0x0000. `borrow_o[u]` is high for exactly the cycle after an edge where unit u stepped down from 0x0000 to 0xFFFF.
- R7: With `cascade_i`=1, the following hold:
  - `count_o` behaves as one 32-bit counter driven by unit 0's strobes, and unit 1 steps in the same edge as unit 0 wraps.
  - `carry_o[1]` and `borrow_o[1]` flag 32-bit wraps.
  - Unit 1's strobe, clear, load and capture pins have no effect.
- R8: With `cascade_i`=1, the following hold:
  - A load event on unit 0's pin loads both halves at the same edge.
  - A capture event on unit 0's pin captures both halves at the same edge.
  - Unit 0's clear pin clears both halves.
- R9: Register port behaviour:
  - `addr_i[2]` selects the unit. `addr_i[1:0]` selects the register: 0 = preload, 1 = count, 2 = capture, 3 = reads zero.
  - A write with `wr_i`=1 changes only the preload register, and only when the selector is 0.
  - `rdata_o` is registered. After an edge it shows the addressed value as it was just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cascade_i | input | 1 | 1 joins the units into one 32-bit counter |
| aclr_mode_i | input | 1 | 1 makes the clear pins act asynchronously |
| up_i | input | 2 | Up strobe per unit |
| dn_i | input | 2 | Down strobe per unit |
| clr_i | input | 2 | Clear pin per unit, active high |
| ld_n_i | input | 2 | Load pin per unit, acts on its falling edge |
| lt_n_i | input | 2 | Capture pin per unit, acts on its falling edge |
| wr_i | input | 1 | Register write enable |
| addr_i | input | 3 | {unit, register select} |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| count_o | output | 32 | {unit 1 count, unit 0 count} |
| carry_o | output | 2 | Per-unit up-wrap flag |
| borrow_o | output | 2 | Per-unit down-wrap flag |

## Verification
The bench builds the block with its default width of 16 bits. With that width, writing preload values at or next to 0xFFFF and 0x0000 and then loading them brings both the 16-bit wraps and the 32-bit cascade wraps within a few cycles. Random runs cover every combination of the cascade and clear-mode pins. Strobes collide with load and clear events, so the priority order is exercised many times.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  typedef enum logic [1:0] {
    SEL_PRE  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CAP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/updn_fall_det.sv
module updn_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= pin_n_i;
  end

  assign fall_o = prev_q & ~pin_n_i;
endmodule

// File: rtl/updn_cnt_unit.sv
module updn_cnt_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         aclr_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic         lt_i,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         pre_we_i,
  input  logic [W-1:0] pre_d_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] lat_o,
  output logic         cy_next_o,
  output logic         bw_next_o,
  output logic         cy_o,
  output logic         bw_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, pre_q, lat_q;
  logic         inc, dec;

  assign inc = up_i & ~dn_i & ~ld_i & ~clr_i;
  assign dec = dn_i & ~up_i & ~ld_i & ~clr_i;
  assign cy_next_o = inc & (cnt_q == TOP);
  assign bw_next_o = dec & (cnt_q == '0);

  always_ff @(posedge clk or posedge aclr_i) begin
    if (aclr_i)             cnt_q <= '0;
    else if (rst || clr_i)  cnt_q <= '0;
    else if (ld_i)          cnt_q <= pre_q;
    else if (inc)           cnt_q <= cnt_q + 1'b1;
    else if (dec)           cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      lat_q <= '0;
      cy_o  <= 1'b0;
      bw_o  <= 1'b0;
    end else begin
      if (pre_we_i) pre_q <= pre_d_i;
      if (lt_i)     lat_q <= cnt_q;
      cy_o <= cy_next_o;
      bw_o <= bw_next_o;
    end
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;
  assign lat_o = lat_q;

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (rst || aclr_i)
    (up_i && !dn_i && !ld_i && !clr_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst || aclr_i)
    (ld_i && !clr_i) |=> cnt_q == $past(pre_q));
  // R4
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    lt_i |=> lat_q == $past(cnt_q));
  // R5
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
  // R6
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst || aclr_i)
    cy_o |-> (cnt_q == '0 && !bw_o));
  // R6
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (rst || aclr_i)
    bw_o |-> cnt_q == TOP);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_cnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cascade_i,
  input  logic           aclr_mode_i,
  input  logic [1:0]     up_i,
  input  logic [1:0]     dn_i,
  input  logic [1:0]     clr_i,
  input  logic [1:0]     ld_n_i,
  input  logic [1:0]     lt_n_i,
  input  logic           wr_i,
  input  logic [2:0]     addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [2*W-1:0] count_o,
  output logic [1:0]     carry_o,
  output logic [1:0]     borrow_o
);
  logic [1:0] ld_fall, lt_fall;
  logic       cy_lo, bw_lo, cy_hi, bw_hi;
  logic       hi_up, hi_dn, hi_clr, hi_ld, hi_lt;
  logic       acl_lo, acl_hi, we_lo, we_hi;
  logic [W-1:0] cnt_lo, cnt_hi, pre_lo, pre_hi, lat_lo, lat_hi;
  logic [W-1:0] rd_q, rd_cnt, rd_pre, rd_lat;
  reg_sel_e   sel;

  updn_fall_det #(.N(2)) u_ld_det (.clk(clk), .rst(rst), .pin_n_i(ld_n_i), .fall_o(ld_fall));
  updn_fall_det #(.N(2)) u_lt_det (.clk(clk), .rst(rst), .pin_n_i(lt_n_i), .fall_o(lt_fall));

  assign hi_up  = cascade_i ? cy_lo      : up_i[1];
  assign hi_dn  = cascade_i ? bw_lo      : dn_i[1];
  assign hi_clr = cascade_i ? clr_i[0]   : clr_i[1];
  assign hi_ld  = cascade_i ? ld_fall[0] : ld_fall[1];
  assign hi_lt  = cascade_i ? lt_fall[0] : lt_fall[1];
  assign acl_lo = aclr_mode_i & clr_i[0];
  assign acl_hi = aclr_mode_i & hi_clr;

  assign sel   = reg_sel_e'(addr_i[1:0]);
  assign we_lo = wr_i && (sel == SEL_PRE) && !addr_i[2];
  assign we_hi = wr_i && (sel == SEL_PRE) &&  addr_i[2];

  updn_cnt_unit #(.W(W)) u_lo (
    .clk(clk), .rst(rst), .aclr_i(acl_lo), .clr_i(clr_i[0]),
    .ld_i(ld_fall[0]), .lt_i(lt_fall[0]), .up_i(up_i[0]), .dn_i(dn_i[0]),
    .pre_we_i(we_lo), .pre_d_i(wdata_i),
    .cnt_o(cnt_lo), .pre_o(pre_lo), .lat_o(lat_lo),
    .cy_next_o(cy_lo), .bw_next_o(bw_lo), .cy_o(carry_o[0]), .bw_o(borrow_o[0])
  );

  updn_cnt_unit #(.W(W)) u_hi (
    .clk(clk), .rst(rst), .aclr_i(acl_hi), .clr_i(hi_clr),
    .ld_i(hi_ld), .lt_i(hi_lt), .up_i(hi_up), .dn_i(hi_dn),
    .pre_we_i(we_hi), .pre_d_i(wdata_i),
    .cnt_o(cnt_hi), .pre_o(pre_hi), .lat_o(lat_hi),
    .cy_next_o(cy_hi), .bw_next_o(bw_hi), .cy_o(carry_o[1]), .bw_o(borrow_o[1])
  );

  assign rd_cnt = addr_i[2] ? cnt_hi : cnt_lo;
  assign rd_pre = addr_i[2] ? pre_hi : pre_lo;
  assign rd_lat = addr_i[2] ? lat_hi : lat_lo;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      unique case (sel)
        SEL_PRE: rd_q <= rd_pre;
        SEL_CNT: rd_q <= rd_cnt;
        SEL_CAP: rd_q <= rd_lat;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rdata_o = rd_q;
  assign count_o = {cnt_hi, cnt_lo};

  // R7
  casc_step_chk: assert property (@(posedge clk) disable iff (rst || acl_hi)
    (cascade_i && cy_lo && !hi_ld && !hi_clr) |=> cnt_hi == W'($past(cnt_hi) + 1'b1));
  // R8
  casc_load_chk: assert property (@(posedge clk) disable iff (rst || acl_lo)
    (cascade_i && ld_fall[0] && !clr_i[0]) |=> count_o == $past({pre_hi, pre_lo}));
  // R9
  write_only_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_PRE) |=> (pre_lo == $past(pre_lo) && pre_hi == $past(pre_hi)));
endmodule

// File: tb/updn_cascade_counter_tb.sv
module updn_cascade_counter_tb;
  logic        clk = 0, rst = 1, cascade = 0, amode = 0, wr = 0;
  logic [1:0]  up = 0, dn = 0, clr = 0, ld_n = 2'b11, lt_n = 2'b11;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [31:0] count;
  logic [1:0]  carry, borrow;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cnt [2], m_pre [2], m_lat [2];
  logic [1:0]  m_ldp, m_ltp, m_cy, m_bw;
  logic [15:0] m_rd;

  always #2 clk = ~clk;

  updn_cascade_counter #(.W(16)) u_dut (
    .clk(clk), .rst(rst), .cascade_i(cascade), .aclr_mode_i(amode),
    .up_i(up), .dn_i(dn), .clr_i(clr), .ld_n_i(ld_n), .lt_n_i(lt_n),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .count_o(count), .carry_o(carry), .borrow_o(borrow)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_cnt[u] = 0; m_pre[u] = 0; m_lat[u] = 0;
    end
    m_ldp = 2'b11; m_ltp = 2'b11; m_cy = 0; m_bw = 0; m_rd = 0;
  endtask

  task automatic unit_next(input logic [15:0] c, input logic [15:0] p,
                           input logic cl, input logic ld, input logic u, input logic d,
                           output logic [15:0] n, output logic cy, output logic bw);
    cy = 0; bw = 0;
    if (cl)            n = 0;
    else if (ld)       n = p;
    else if (u && !d) begin n = c + 1; cy = (c == 16'hFFFF); end
    else if (d && !u) begin n = c - 1; bw = (c == 16'h0000); end
    else               n = c;
  endtask

  task automatic model_update();
    logic [15:0] c0, c1, n0, n1;
    logic lf0, lf1, tf0, tf1, cl1, cy0, bw0, cy1, bw1;
    logic [1:0] s;
    lf0 = m_ldp[0] & ~ld_n[0]; lf1 = m_ldp[1] & ~ld_n[1];
    tf0 = m_ltp[0] & ~lt_n[0]; tf1 = m_ltp[1] & ~lt_n[1];
    cl1 = cascade ? clr[0] : clr[1];
    c0 = (amode && clr[0]) ? 16'h0 : m_cnt[0];
    c1 = (amode && cl1) ? 16'h0 : m_cnt[1];
    s = addr[1:0];
    case (s)
      2'd0: m_rd = m_pre[addr[2]];
      2'd1: m_rd = addr[2] ? c1 : c0;
      2'd2: m_rd = m_lat[addr[2]];
      default: m_rd = 0;
    endcase
    unit_next(c0, m_pre[0], clr[0], lf0, up[0], dn[0], n0, cy0, bw0);
    if (cascade) unit_next(c1, m_pre[1], clr[0], lf0, cy0, bw0, n1, cy1, bw1);
    else         unit_next(c1, m_pre[1], clr[1], lf1, up[1], dn[1], n1, cy1, bw1);
    if (tf0) m_lat[0] = c0;
    if (cascade ? tf0 : tf1) m_lat[1] = c1;
    m_cnt[0] = n0; m_cnt[1] = n1;
    m_cy = {cy1, cy0}; m_bw = {bw1, bw0};
    if (wr && s == 2'd0) m_pre[addr[2]] = wdata;
    m_ldp = ld_n; m_ltp = lt_n;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2 count", count, {m_cnt[1], m_cnt[0]});
    chk("R6 carry/borrow", {carry, borrow}, {m_cy, m_bw});
    chk("R9 rdata", rdata, m_rd);
  endtask

  task automatic idle();
    up = 0; dn = 0; clr = 0; ld_n = 2'b11; lt_n = 2'b11; wr = 0;
  endtask

  task automatic write_pre(input logic u, input logic [15:0] v);
    wr = 1; addr = {u, 2'd0}; wdata = v; step(); wr = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5EED_0011);
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset flags", {carry, borrow}, 0);
    chk("R1 reset rdata", rdata, 0);

    // R3: load beats a same-cycle up strobe
    write_pre(0, 16'hFFFE);
    ld_n[0] = 0; up[0] = 1; step(); idle();
    chk("R3 load wins", count[15:0], 16'hFFFE);
    up[0] = 1; step(); step(); idle();
    chk("R6 up wrap", {count[15:0], carry[0]}, {16'h0000, 1'b1});
    up[0] = 1; step(); idle();
    lt_n[0] = 0; up[0] = 1; step(); idle();
    addr = 3'b010; step();
    chk("R4 capture pre-edge count", rdata, 16'h0001);
    dn[0] = 1; step(); step(); step(); idle();
    chk("R6 down wrap", {count[15:0], borrow[0]}, {16'hFFFF, 1'b1});

    // R5: async versus sync clear between edges
    amode = 1; clr[0] = 1; #1;
    chk("R5 async clear immediate", count[15:0], 16'h0000);
    step(); idle();
    up[0] = 1; step(); idle();
    amode = 0; clr[0] = 1; #1;
    chk("R5 sync clear waits for edge", count[15:0], 16'h0001);
    ld_n[0] = 0; step(); idle();
    chk("R5 sync clear beats load", count[15:0], 16'h0000);

    // R7/R8: cascade
    write_pre(0, 16'hFFFF); write_pre(1, 16'h0012);
    cascade = 1;
    ld_n[0] = 0; step(); idle();
    chk("R8 coherent load", count, 32'h0012FFFF);
    up[0] = 1; dn[1] = 1; ld_n[1] = 0; step(); idle();
    chk("R7 cascade carry", count, 32'h00130000);
    dn[0] = 1; step(); idle();
    chk("R7 cascade borrow", count, 32'h0012FFFF);
    clr[1] = 1; step(); idle();
    chk("R7 high pins ignored", count, 32'h0012FFFF);
    clr[0] = 1; step(); idle();
    chk("R8 clear both halves", count, 32'h0);
    cascade = 0;

    // random phases over every cascade/clear-mode pairing
    for (int p = 0; p < 8; p++) begin
      cascade = p[0]; amode = p[1];
      for (int i = 0; i < 1500; i++) begin
        int r;
        r = $urandom % 8;
        up   = (p[2] ? (r < 5) : (r < 2)) ? 2'b11 : 2'($urandom);
        dn   = (p[2] ? (r >= 6) : (r >= 3)) ? 2'b11 : 2'($urandom);
        ld_n = {($urandom % 10) != 0, ($urandom % 10) != 0};
        lt_n = {($urandom % 6) != 0, ($urandom % 6) != 0};
        clr  = {($urandom % 40) == 0, ($urandom % 40) == 0};
        wr   = ($urandom % 4) == 0;
        addr = 3'($urandom);
        case ($urandom % 4)
          0: wdata = 16'hFFFF;
          1: wdata = 16'h0000;
          2: wdata = 16'hFFFE;
          default: wdata = 16'($urandom);
        endcase
        step();
      end
      idle(); step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule